// File: doc/BRIEF.md
# Programmable Periodic / One-Shot Event Timer

This block is a down-counting event timer. It advances only on cycles where a tick enable is high; the tick is normally a one-microsecond strobe generated outside the block. Software programs it through two 32-bit registers. One write to the control register sets the enable, selects periodic or single-shot operation and loads the count. The count is written as the wanted delay minus one, so a value of V gives an event on the (V+1)-th tick.

When the counter is at zero on a tick, the timer sets a pending flag. That flag drives an active-high level interrupt. In periodic mode the counter then reloads the programmed value and keeps running. In single-shot mode the enable clears itself and the counter stays at zero. The interrupt stays high until software writes a one to the acknowledge bit of the status register. Reading the status register returns the live counter and the pending flag. With a 1 MHz tick, a periodic value of 1000000/F - 1 gives F interrupts per second.

Top module: `evt_timer`

## Requirements
- R1: After reset the interrupt is low and both registers read as zero.
- R2: A write to offset 0x0 stores bit 31 as enable, bit 30 as periodic mode and bits 28:0 as the reload value. Reading offset 0x0 returns those fields in the same positions, with bit 29 read as zero.
- R3: While enabled, each tick with a nonzero counter decrements it by one. Without a tick, or while disabled, the counter holds its value.
- R4: After a value V is written with enable set, the pending flag and the interrupt rise after exactly V+1 ticks.
- R5: In periodic mode an expiry reloads the counter with the programmed value and keeps the timer enabled, so interrupts recur every V+1 ticks.
- R6: In single-shot mode an expiry clears the enable bit and leaves the counter at zero. Further ticks cause no new expiry.
- R7: The interrupt is a level that stays high until offset 0x4 is written with bit 30 set. A write there with bit 30 clear has no effect.
- R8: A write to offset 0x0 loads the new count at once and restarts the countdown. It takes precedence over a tick in the same cycle and does not change the pending flag.
- R9: Reading offset 0x4 returns the live counter in bits 28:0 and the pending flag in bit 30. All other bits read zero.
- R10: If an expiry and an acknowledge fall in the same cycle, the pending flag ends up set.
- R11: Writing zero to offset 0x0 stops the timer, and no interrupt follows.
- R12: Offsets other than 0x0 and 0x4 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable strobe (one per microsecond) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Active-high level interrupt |

## Verification
The hardest situation to reach from the ports is an expiry that falls in the same cycle as an acknowledge write, while an earlier event is still pending. The bench isolates each tick with an idle cycle so that it always knows the counter value. It issues exactly the ticks that bring a periodic count to zero. It then merges the final tick with the acknowledge write in one cycle. The same precise tick control lets the bench also land a control write on a tick cycle.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int CNT_W = 29
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam logic [2:0] OFS_CTRL = 3'h0;
  localparam logic [2:0] OFS_STAT = 3'h4;
  localparam int EN_B   = 31;
  localparam int PER_B  = 30;
  localparam int ACK_B  = 30;
  localparam int PEND_B = 30;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             en_q, per_q, pend_q;
  logic [CNT_W-1:0] rel_q, cnt_q;

  wire wr_ctrl = wr_en && (addr == OFS_CTRL);
  wire wr_ack  = wr_en && (addr == OFS_STAT) && wdata[ACK_B];
  wire at_zero = (cnt_q == '0);
  wire expire  = tick && en_q && at_zero && !wr_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      pend_q <= 1'b0;
      rel_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[EN_B];
        per_q <= wdata[PER_B];
        rel_q <= wdata[CNT_W-1:0];
        cnt_q <= wdata[CNT_W-1:0];
      end else if (tick && en_q) begin
        if (at_zero) begin
          if (per_q) cnt_q <= rel_q;
          else       en_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
      if (expire)      pend_q <= 1'b1;
      else if (wr_ack) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: begin
        rdata[EN_B]        = en_q;
        rdata[PER_B]       = per_q;
        rdata[CNT_W-1:0]   = rel_q;
      end
      OFS_STAT: begin
        rdata[PEND_B]      = pend_q;
        rdata[CNT_W-1:0]   = cnt_q;
      end
      default: rdata = '0;
    endcase
  end

  assign irq = pend_q;
endmodule

module evt_timer_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [31:0]      wdata,
  input logic             irq,
  input logic             en,
  input logic             per,
  input logic [CNT_W-1:0] rel,
  input logic [CNT_W-1:0] cnt
);
  wire c_wr = wr_en && addr == 3'h0;
  wire c_ack = wr_en && addr == 3'h4 && wdata[30];

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && en && cnt != '0 && !c_wr |=> cnt == $past(cnt) - CNT_W'(1));
  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick || !en) && !c_wr |=> $stable(cnt));
  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick && en && cnt == '0 && !c_wr));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && en && per && cnt == '0 && !c_wr |=> en && cnt == $past(rel));
  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && en && !per && cnt == '0 && !c_wr |=> !en && cnt == '0);
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !c_ack |=> irq);
  // R8
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr |=> cnt == $past(wdata[CNT_W-1:0]) && en == $past(wdata[31]));
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && en && cnt == '0 && !c_wr && c_ack |=> irq);
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .en(en_q), .per(per_q), .rel(rel_q), .cnt(cnt_q)
);

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = 3'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  evt_timer u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_en, m_per, m_pend;
  longint m_rel, m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_per = 0; m_pend = 0; m_rel = 0; m_cnt = 0;
    end else begin
      bit wc, ack, ex;
      wc  = wr_en && addr == 3'h0;
      ack = wr_en && addr == 3'h4 && wdata[30];
      ex  = tick && m_en && m_cnt == 0 && !wc;
      if (wc) begin
        m_en = wdata[31]; m_per = wdata[30];
        m_rel = wdata[28:0]; m_cnt = m_rel;
      end else if (tick && m_en) begin
        if (m_cnt == 0) begin
          if (m_per) m_cnt = m_rel; else m_en = 0;
        end else m_cnt = m_cnt - 1;
      end
      if (ex) m_pend = 1; else if (ack) m_pend = 0;
    end
  end

  function automatic logic [31:0] model_read(logic [2:0] a);
    logic [31:0] v = '0;
    if (a == 3'h0) begin v[31] = m_en; v[30] = m_per; v[28:0] = m_rel[28:0]; end
    else if (a == 3'h4) begin v[30] = m_pend; v[28:0] = m_cnt[28:0]; end
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic w, input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    if (rst_n) begin
      chk({31'b0, irq}, {31'b0, m_pend}, {cur_req, " irq vs model"});
      chk(rdata, model_read(addr), {cur_req, " rdata vs model"});
    end
    tick = t; wr_en = w; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    step(0, 0, a, 0); #1;
    chk(rdata, exp, req);
  endtask

  // one isolated tick; returns after its effect is visible
  task automatic one_tick();
    step(1, 0, 3'h4, 0);
    step(0, 0, 3'h4, 0); #1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int n, first, second;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    rd(3'h0, 32'h0, "R1 ctrl after reset");
    rd(3'h4, 32'h0, "R1 status after reset");
    chk({31'b0, irq}, 32'h0, "R1 irq after reset");

    cur_req = "R2";
    step(0, 1, 3'h0, 32'hFFFF_FFFF);
    rd(3'h0, 32'hDFFF_FFFF, "R2 max readback");
    step(0, 1, 3'h0, 32'h0);

    cur_req = "R12";
    step(0, 1, 3'h2, 32'hFFFF_FFFF);
    rd(3'h2, 32'h0, "R12 unused offset reads zero");
    rd(3'h0, 32'h0, "R12 ctrl unchanged");

    cur_req = "R3";
    step(0, 1, 3'h0, 32'h8000_0004);
    repeat (4) step(0, 0, 3'h4, 0);
    rd(3'h4, 32'h0000_0004, "R3 hold without tick");
    one_tick();
    chk(rdata, 32'h0000_0003, "R3 decrement");

    cur_req = "R4";
    step(0, 1, 3'h0, 32'h8000_0004);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      one_tick(); n++;
      if (irq) break;
    end
    chk(n, 5, "R4 ticks to expiry");
    cur_req = "R6";
    rd(3'h0, 32'h0000_0004, "R6 enable self-cleared");
    repeat (6) one_tick();
    chk(rdata, 32'h4000_0000, "R9 R6 status zero count pending");

    cur_req = "R7";
    step(0, 1, 3'h4, 32'hBFFF_FFFF);
    step(0, 0, 3'h4, 0); #1;
    chk({31'b0, irq}, 32'h1, "R7 ack without bit30 ignored");
    step(0, 1, 3'h4, 32'h4000_0000);
    step(0, 0, 3'h4, 0); #1;
    chk({31'b0, irq}, 32'h0, "R7 ack clears");

    cur_req = "R5";
    step(0, 1, 3'h0, 32'hC000_0002);
    n = 0; first = 0; second = 0;
    for (int k = 0; k < 30 && second == 0; k++) begin
      one_tick(); n++;
      if (irq) begin
        if (first == 0) first = n; else second = n;
        step(0, 1, 3'h4, 32'h4000_0000);
      end
    end
    chk(first, 3, "R5 first period");
    chk(second - first, 3, "R5 second period");
    rd(3'h0, 32'hC000_0002, "R5 still enabled");

    cur_req = "R10";
    step(0, 1, 3'h0, 32'hC000_0002);
    repeat (3) one_tick();
    chk({31'b0, irq}, 32'h1, "R10 pending before");
    one_tick(); one_tick();
    step(1, 1, 3'h4, 32'h4000_0000);
    step(0, 0, 3'h4, 0); #1;
    chk({31'b0, irq}, 32'h1, "R10 set wins over ack");
    chk(rdata, 32'h4000_0002, "R10 R9 status after reload");

    cur_req = "R8";
    one_tick();
    step(1, 1, 3'h0, 32'hC000_0009);
    rd(3'h4, 32'h4000_0009, "R8 restart beats tick, pending kept");
    one_tick();
    chk(rdata, 32'h4000_0008, "R8 count continues");

    cur_req = "R11";
    step(0, 1, 3'h0, 32'h0);
    step(0, 1, 3'h4, 32'h4000_0000);
    repeat (15) one_tick();
    chk({31'b0, irq}, 32'h0, "R11 no interrupt after stop");
    rd(3'h0, 32'h0, "R11 ctrl zero");

    step(0, 0, 3'h0, 0);
    finish_up();
  end
endmodule